// File: doc/BRIEF.md
# Decode-Stage Stall Controller

This block decides, for an in-order five-stage pipeline that has no operand bypass network, whether the instruction sitting in the decode register may advance. Each cycle it compares the two source register numbers held in the fetch/decode register with the destination numbers of the three younger-to-older stages downstream (execute, memory, writeback). A comparison only counts when that stage will actually write a register. Register zero is hard-wired and never creates a dependence.

On a dependence the block freezes the program counter and the fetch/decode register and injects an empty slot into the decode/execute register, with both its register-write and memory-write controls cleared. Because no value is forwarded, a consumer must wait until its producer has left the writeback stage. A consumer that directly follows its producer therefore waits three cycles in decode. The block includes a small model of the PC and the stage registers, so that stall behaviour can be observed at the pins. Each fetched instruction is presented as two source fields, a destination field, two write controls and an identifying tag.

Top module: `dec_hazard_unit`

## Requirements
- R1: `stall_o` is 1 when source A of the decode slot is nonzero and equals the destination of any of the execute, memory or writeback slots whose register-write control is 1.
- R2: The same test applies to source B, and `stall_o` is the OR of the source A and source B results.
- R3: A source field of 0 never raises `stall_o`, even when a downstream slot writes register 0.
- R4: A downstream slot whose register-write control is 0, such as a store or an empty slot, never raises `stall_o`, whatever its destination field holds.
- R5: In a stall cycle `ifid_we_o` is 0, and on the next cycle the decode slot, seen through `ifid_tag_o`, is unchanged. `pc_we_o`, `ifid_we_o` and `bubble_o` always agree with `stall_o`.
- R6: In a stall cycle `pc_we_o` is 0 and `pc_o` holds its value on the next cycle.
- R7: In a stall cycle `bubble_o` is 1, and on the next cycle the execute slot is empty: `idex_tag_o`=0, `idex_reg_wr_o`=0, `idex_mem_wr_o`=0.
- R8: In a cycle without a stall, `pc_o` increments by 1. The decode slot takes the fetch inputs, and the execute slot takes the old decode slot, including its tag and both write controls.
- R9: A consumer placed 1, 2, 3 or 4 instructions after its producer spends 3, 2, 1 or 0 stall cycles in decode. No run of consecutive stalls is longer than 3 cycles.
- R10: After reset `pc_o`=0, the decode and execute slots are empty (tag 0), and `stall_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| if_src_a_i | input | REG_W | Source A register of the fetched instruction |
| if_src_b_i | input | REG_W | Source B register of the fetched instruction |
| if_dst_i | input | REG_W | Destination register of the fetched instruction |
| if_reg_wr_i | input | 1 | Fetched instruction writes a register |
| if_mem_wr_i | input | 1 | Fetched instruction writes memory |
| if_tag_i | input | TAG_W | Identifier of the fetched instruction (0 means empty) |
| pc_o | output | PC_W | Program counter |
| stall_o | output | 1 | Decode slot must wait |
| pc_we_o | output | 1 | PC update enable |
| ifid_we_o | output | 1 | Fetch/decode register write enable |
| bubble_o | output | 1 | Clear the controls entering the execute slot |
| ifid_tag_o | output | TAG_W | Tag held in the decode slot |
| idex_tag_o | output | TAG_W | Tag held in the execute slot |
| idex_dst_o | output | REG_W | Destination held in the execute slot |
| idex_reg_wr_o | output | 1 | Register-write control in the execute slot |
| idex_mem_wr_o | output | 1 | Memory-write control in the execute slot |

## Verification
Short programs place a consumer 1, 2, 3 and 4 instructions behind its producer, on source A and then on source B. The resulting stall counts show whether each of the three downstream comparisons is present and correctly aligned. A pair of producers feeding both sources at different distances shows that the two sources are ORed rather than tested in sequence. A producer that writes register 0, and a store whose destination field matches a later source, must give no stall: these runs expose a missing zero check or a missing write-enable qualification. Every cycle of every run is also checked for frozen PC and decode slot, empty execute slot after a stall, and plain advance otherwise.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  // downstream slots compared against: execute, memory, writeback
  localparam int unsigned HZ_NSTG = 3;
  localparam int unsigned HZ_NSRC = 2;
  localparam int unsigned STG_EX  = 0;
  localparam int unsigned STG_MEM = 1;
  localparam int unsigned STG_WB  = 2;
endpackage

// File: rtl/hzd_src_match.sv
module hzd_src_match #(
  parameter int unsigned REG_W = 3,
  parameter int unsigned NSTG  = 3
) (
  input  logic [REG_W-1:0]           src_i,
  input  logic [NSTG-1:0][REG_W-1:0] dst_i,
  input  logic [NSTG-1:0]            wr_i,
  output logic                       hit_o
);
  logic [NSTG-1:0] stg_hit;

  for (genvar g = 0; g < NSTG; g++) begin : g_stg
    assign stg_hit[g] = wr_i[g] && (dst_i[g] == src_i);
  end

  // r0 is hard-wired, never a true dependence
  assign hit_o = (src_i != '0) && (|stg_hit);
endmodule

// File: rtl/hzd_detect.sv
module hzd_detect
  import hzd_pkg::*;
#(
  parameter int unsigned REG_W = 3
) (
  input  logic [HZ_NSRC-1:0][REG_W-1:0] src_i,
  input  logic [HZ_NSTG-1:0][REG_W-1:0] dst_i,
  input  logic [HZ_NSTG-1:0]            wr_i,
  output logic                          stall_o,
  output logic                          pc_we_o,
  output logic                          ifid_we_o,
  output logic                          bubble_o
);
  logic [HZ_NSRC-1:0] src_hit;

  for (genvar s = 0; s < HZ_NSRC; s++) begin : g_src
    hzd_src_match #(
      .REG_W(REG_W),
      .NSTG (HZ_NSTG)
    ) u_match (
      .src_i(src_i[s]),
      .dst_i(dst_i),
      .wr_i (wr_i),
      .hit_o(src_hit[s])
    );
  end

  assign stall_o   = |src_hit;
  assign pc_we_o   = ~stall_o;
  assign ifid_we_o = ~stall_o;
  assign bubble_o  = stall_o;
endmodule

// File: rtl/hzd_pipe_regs.sv
module hzd_pipe_regs
  import hzd_pkg::*;
#(
  parameter int unsigned REG_W = 3,
  parameter int unsigned PC_W  = 8,
  parameter int unsigned TAG_W = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          pc_we_i,
  input  logic                          ifid_we_i,
  input  logic                          bubble_i,
  input  logic [REG_W-1:0]              f_src_a_i,
  input  logic [REG_W-1:0]              f_src_b_i,
  input  logic [REG_W-1:0]              f_dst_i,
  input  logic                          f_reg_wr_i,
  input  logic                          f_mem_wr_i,
  input  logic [TAG_W-1:0]              f_tag_i,
  output logic [PC_W-1:0]               pc_o,
  output logic [HZ_NSRC-1:0][REG_W-1:0] dec_src_o,
  output logic [TAG_W-1:0]              dec_tag_o,
  output logic [HZ_NSTG-1:0][REG_W-1:0] stg_dst_o,
  output logic [HZ_NSTG-1:0]            stg_wr_o,
  output logic [TAG_W-1:0]              ex_tag_o,
  output logic                          ex_mem_wr_o
);
  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [REG_W-1:0] src_a;
    logic [REG_W-1:0] src_b;
    logic [REG_W-1:0] dst;
    logic             reg_wr;
    logic             mem_wr;
  } dec_slot_t;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [REG_W-1:0] dst;
    logic             reg_wr;
    logic             mem_wr;
  } ex_slot_t;

  typedef struct packed {
    logic [REG_W-1:0] dst;
    logic             reg_wr;
  } wr_slot_t;

  logic [PC_W-1:0] pc_q;
  dec_slot_t       dec_q, fetch_d;
  ex_slot_t        ex_q, ex_d;
  wr_slot_t        mem_q, wb_q;

  always_comb begin
    fetch_d = '{tag: f_tag_i, src_a: f_src_a_i, src_b: f_src_b_i,
                dst: f_dst_i, reg_wr: f_reg_wr_i, mem_wr: f_mem_wr_i};
    ex_d    = '{tag: dec_q.tag, dst: dec_q.dst,
                reg_wr: dec_q.reg_wr, mem_wr: dec_q.mem_wr};
    if (bubble_i) ex_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      dec_q <= '0;
      ex_q  <= '0;
      mem_q <= '0;
      wb_q  <= '0;
    end else begin
      if (pc_we_i)   pc_q  <= pc_q + PC_W'(1);
      if (ifid_we_i) dec_q <= fetch_d;
      ex_q  <= ex_d;
      mem_q <= '{dst: ex_q.dst, reg_wr: ex_q.reg_wr};
      wb_q  <= mem_q;
    end
  end

  assign pc_o         = pc_q;
  assign dec_src_o[0] = dec_q.src_a;
  assign dec_src_o[1] = dec_q.src_b;
  assign dec_tag_o    = dec_q.tag;

  assign stg_dst_o[STG_EX]  = ex_q.dst;
  assign stg_dst_o[STG_MEM] = mem_q.dst;
  assign stg_dst_o[STG_WB]  = wb_q.dst;
  assign stg_wr_o[STG_EX]   = ex_q.reg_wr;
  assign stg_wr_o[STG_MEM]  = mem_q.reg_wr;
  assign stg_wr_o[STG_WB]   = wb_q.reg_wr;

  assign ex_tag_o    = ex_q.tag;
  assign ex_mem_wr_o = ex_q.mem_wr;
endmodule

// File: rtl/dec_hazard_unit.sv
module dec_hazard_unit
  import hzd_pkg::*;
#(
  parameter int unsigned REG_W = 3,
  parameter int unsigned PC_W  = 8,
  parameter int unsigned TAG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] if_src_a_i,
  input  logic [REG_W-1:0] if_src_b_i,
  input  logic [REG_W-1:0] if_dst_i,
  input  logic             if_reg_wr_i,
  input  logic             if_mem_wr_i,
  input  logic [TAG_W-1:0] if_tag_i,
  output logic [PC_W-1:0]  pc_o,
  output logic             stall_o,
  output logic             pc_we_o,
  output logic             ifid_we_o,
  output logic             bubble_o,
  output logic [TAG_W-1:0] ifid_tag_o,
  output logic [TAG_W-1:0] idex_tag_o,
  output logic [REG_W-1:0] idex_dst_o,
  output logic             idex_reg_wr_o,
  output logic             idex_mem_wr_o
);
  logic [HZ_NSRC-1:0][REG_W-1:0] dec_src;
  logic [HZ_NSTG-1:0][REG_W-1:0] stg_dst;
  logic [HZ_NSTG-1:0]            stg_wr;

  hzd_pipe_regs #(
    .REG_W(REG_W),
    .PC_W (PC_W),
    .TAG_W(TAG_W)
  ) u_pipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pc_we_i    (pc_we_o),
    .ifid_we_i  (ifid_we_o),
    .bubble_i   (bubble_o),
    .f_src_a_i  (if_src_a_i),
    .f_src_b_i  (if_src_b_i),
    .f_dst_i    (if_dst_i),
    .f_reg_wr_i (if_reg_wr_i),
    .f_mem_wr_i (if_mem_wr_i),
    .f_tag_i    (if_tag_i),
    .pc_o       (pc_o),
    .dec_src_o  (dec_src),
    .dec_tag_o  (ifid_tag_o),
    .stg_dst_o  (stg_dst),
    .stg_wr_o   (stg_wr),
    .ex_tag_o   (idex_tag_o),
    .ex_mem_wr_o(idex_mem_wr_o)
  );

  hzd_detect #(
    .REG_W(REG_W)
  ) u_detect (
    .src_i    (dec_src),
    .dst_i    (stg_dst),
    .wr_i     (stg_wr),
    .stall_o  (stall_o),
    .pc_we_o  (pc_we_o),
    .ifid_we_o(ifid_we_o),
    .bubble_o (bubble_o)
  );

  assign idex_dst_o    = stg_dst[STG_EX];
  assign idex_reg_wr_o = stg_wr[STG_EX];
endmodule

// File: rtl/hzd_sva.sv
module hzd_sva #(
  parameter int unsigned PC_W  = 8,
  parameter int unsigned TAG_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             stall_o,
  input logic [PC_W-1:0]  pc_o,
  input logic [TAG_W-1:0] ifid_tag_o,
  input logic [TAG_W-1:0] idex_tag_o,
  input logic             idex_reg_wr_o,
  input logic             idex_mem_wr_o
);
  logic [2:0] stall_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 stall_run <= '0;
    else if (!stall_o)           stall_run <= '0;
    else if (stall_run != 3'd7)  stall_run <= stall_run + 3'd1;
  end

  p_pc_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> (pc_o == $past(pc_o)));

  p_dec_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> $stable(ifid_tag_o));

  p_bubble_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> (!idex_reg_wr_o && !idex_mem_wr_o && idex_tag_o == '0));

  p_advance_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_o |=> (pc_o == $past(pc_o) + PC_W'(1) && idex_tag_o == $past(ifid_tag_o)));

  p_max_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (stall_run < 3'd3));
endmodule

bind dec_hazard_unit hzd_sva #(
  .PC_W (PC_W),
  .TAG_W(TAG_W)
) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stall_o      (stall_o),
  .pc_o         (pc_o),
  .ifid_tag_o   (ifid_tag_o),
  .idex_tag_o   (idex_tag_o),
  .idex_reg_wr_o(idex_reg_wr_o),
  .idex_mem_wr_o(idex_mem_wr_o)
);

// File: tb/sim_dec_hazard_unit.sv
`timescale 1ns/1ps
module sim_dec_hazard_unit;
  localparam int REG_W = 3;
  localparam int PC_W  = 8;
  localparam int TAG_W = 4;
  localparam int PLEN  = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [REG_W-1:0] src_a = '0, src_b = '0, dst = '0;
  logic             reg_wr = 1'b0, mem_wr = 1'b0;
  logic [TAG_W-1:0] tag = '0;
  logic [PC_W-1:0]  pc;
  logic             stall, pc_we, ifid_we, bubble;
  logic [TAG_W-1:0] ifid_tag, idex_tag;
  logic [REG_W-1:0] idex_dst;
  logic             idex_reg_wr, idex_mem_wr;

  int n_tests = 0;
  int n_fail  = 0;

  logic [REG_W-1:0] p_a [PLEN];
  logic [REG_W-1:0] p_b [PLEN];
  logic [REG_W-1:0] p_d [PLEN];
  logic             p_w [PLEN];
  logic             p_m [PLEN];
  int               p_len;

  always #2 clk = ~clk;

  dec_hazard_unit #(.REG_W(REG_W), .PC_W(PC_W), .TAG_W(TAG_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .if_src_a_i(src_a), .if_src_b_i(src_b), .if_dst_i(dst),
    .if_reg_wr_i(reg_wr), .if_mem_wr_i(mem_wr), .if_tag_i(tag),
    .pc_o(pc), .stall_o(stall), .pc_we_o(pc_we), .ifid_we_o(ifid_we),
    .bubble_o(bubble), .ifid_tag_o(ifid_tag), .idex_tag_o(idex_tag),
    .idex_dst_o(idex_dst), .idex_reg_wr_o(idex_reg_wr), .idex_mem_wr_o(idex_mem_wr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < PLEN; i++) begin
      p_a[i] = '0; p_b[i] = '0; p_d[i] = '0; p_w[i] = 1'b0; p_m[i] = 1'b0;
    end
    p_len = 0;
  endtask

  task automatic add_ins(input int a, input int b, input int d, input bit w, input bit m);
    p_a[p_len] = REG_W'(a); p_b[p_len] = REG_W'(b); p_d[p_len] = REG_W'(d);
    p_w[p_len] = w; p_m[p_len] = m;
    p_len++;
  endtask

  // present program[pc] on the fetch inputs; tag = index+1, 0 past the end
  task automatic drive_fetch();
    int idx;
    idx = int'(pc);
    if (idx < p_len) begin
      src_a = p_a[idx]; src_b = p_b[idx]; dst = p_d[idx];
      reg_wr = p_w[idx]; mem_wr = p_m[idx]; tag = TAG_W'(idx + 1);
    end else begin
      src_a = '0; src_b = '0; dst = '0; reg_wr = 1'b0; mem_wr = 1'b0; tag = '0;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    src_a = '0; src_b = '0; dst = '0; reg_wr = 1'b0; mem_wr = 1'b0; tag = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_prog(input int ncyc, output int stalls);
    bit              prev_stall;
    int              prev_pc;
    logic [TAG_W-1:0] prev_ifid, prev_fetch;
    bit              prev_ifid_m, prev_fetch_m, cur_ifid_m;
    do_reset();
    drive_fetch();
    stalls = 0;
    prev_stall = stall; prev_pc = int'(pc); prev_ifid = ifid_tag;
    prev_fetch = tag; prev_fetch_m = mem_wr; prev_ifid_m = 1'b0;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      check(pc_we == !stall && ifid_we == !stall && bubble == stall,
            "R5 enables vs stall", int'({pc_we, ifid_we, bubble}), int'(stall));
      if (prev_stall) begin
        check(int'(pc) == prev_pc, "R6 pc hold", int'(pc), prev_pc);
        check(ifid_tag == prev_ifid, "R5 decode hold", int'(ifid_tag), int'(prev_ifid));
        check(idex_tag == '0 && !idex_reg_wr && !idex_mem_wr, "R7 bubble",
              int'({idex_tag, idex_reg_wr, idex_mem_wr}), 0);
        cur_ifid_m = prev_ifid_m;
      end else begin
        check(int'(pc) == ((prev_pc + 1) % (1 << PC_W)), "R8 pc advance", int'(pc), prev_pc + 1);
        check(ifid_tag == prev_fetch, "R8 decode load", int'(ifid_tag), int'(prev_fetch));
        check(idex_tag == prev_ifid && idex_mem_wr == prev_ifid_m, "R8 execute load",
              int'(idex_tag), int'(prev_ifid));
        cur_ifid_m = prev_fetch_m;
      end
      if (stall) stalls++;
      prev_stall = stall; prev_pc = int'(pc); prev_ifid = ifid_tag; prev_ifid_m = cur_ifid_m;
      drive_fetch();
      prev_fetch = tag; prev_fetch_m = mem_wr;
    end
  endtask

  task automatic t_reset();
    do_reset();
    check(pc == '0, "R10 pc", int'(pc), 0);
    check(!stall && pc_we && ifid_we, "R10 stall", int'(stall), 0);
    check(ifid_tag == '0 && idex_tag == '0 && !idex_reg_wr && !idex_mem_wr,
          "R10 slots", int'({ifid_tag, idex_tag}), 0);
  endtask

  task automatic t_distance(input int d, input bit use_b);
    int st, exp;
    clear_prog();
    add_ins(1, 2, 3, 1'b1, 1'b0);
    for (int i = 1; i < d; i++) add_ins(1, 2, 7, 1'b1, 1'b0);
    if (use_b) add_ins(4, 3, 5, 1'b1, 1'b1);
    else       add_ins(3, 4, 5, 1'b1, 1'b1);
    run_prog(20, st);
    exp = (d < 4) ? 4 - d : 0;
    if (use_b) check(st == exp, "R9 R2 distance stalls src B", st, exp);
    else       check(st == exp, "R9 R1 distance stalls src A", st, exp);
  endtask

  task automatic t_reg_zero();
    int st;
    clear_prog();
    add_ins(1, 2, 0, 1'b1, 1'b0);
    add_ins(0, 0, 5, 1'b1, 1'b0);
    run_prog(16, st);
    check(st == 0, "R3 register zero", st, 0);
  endtask

  task automatic t_no_write();
    int st;
    clear_prog();
    add_ins(1, 2, 3, 1'b0, 1'b1);
    add_ins(3, 3, 5, 1'b1, 1'b0);
    run_prog(16, st);
    check(st == 0, "R4 non-writing producer", st, 0);
  endtask

  task automatic t_both_sources();
    int st;
    clear_prog();
    add_ins(1, 2, 3, 1'b1, 1'b0);
    add_ins(1, 2, 4, 1'b1, 1'b0);
    add_ins(3, 4, 5, 1'b1, 1'b0);
    run_prog(20, st);
    check(st == 3, "R2 both sources ORed", st, 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R9 actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    clear_prog();
    t_reset();
    for (int d = 1; d <= 4; d++) t_distance(d, 1'b0);
    for (int d = 1; d <= 4; d++) t_distance(d, 1'b1);
    t_reg_zero();
    t_no_write();
    t_both_sources();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule